// File: doc/BRIEF.md
# Holdover Frequency History Averager

This block sits beside the loop filter of a digital PLL. While the loop is locked, it stores one frequency-word sample on every sample tick in a circular history. When the selected reference fails and no alternate reference is valid, the block enters holdover on its own. It then produces a held frequency word for the oscillator to coast on.

The held word is the mean of a run of stored samples. The run has a selectable length, and it ends a selectable number of ticks before the failure, so the newest samples are skipped because they may already be corrupt. The sum is built one sample per cycle after entry, and a serial divider then produces the mean. The previous held word stays on the output until the new one is ready. Holdover ends as soon as either reference becomes valid again.

One sample tick stands for one scaled time unit. Parameters map each window code and each delay code to a tick count. By default one tick stands for one scaled second. The 30 ms and 60 ms delay options become one and two ticks. The 120-second history becomes 128 entries.

Top module: `hold_avg_top`

## Requirements
- R1: While `rst_i` is high and on the cycle after it, `hold_active_o` and `avg_ready_o` are 0, `hold_freq_o` is 0, and the stored history is emptied.
- R2: If `sel_valid_i` and `alt_valid_i` are both 0 at a clock edge while not in holdover, `hold_active_o` is 1 after that edge. If either input is 1, holdover is not entered.
- R3: If either valid input is 1 at a clock edge while in holdover, `hold_active_o` and `avg_ready_o` are both 0 after that edge.
- R4: Age 0 is the newest stored sample. The held word is floor(sum / n) over the samples of age D to D+n-1, where D is the delay in ticks and n is the number of samples used.
- R5: Window code `win_sel_i` selects the window length W: 0 gives 4 ticks, 1 gives 10, 2 gives 30 and 3 gives 60.
- R6: Delay code `dly_sel_i` selects D: 0 gives 1 tick, 1 gives 2, 2 gives 4, 3 gives 10, 4 gives 30 and 5 gives 60. Codes 6 and 7 also give 60.
- R7: Let C be the number of stored samples. If C is less than W+D, then n = min(W, C-D). Otherwise n = W.
- R8: If no stored sample is older than D (C <= D), the held word is the newest stored sample, or 0 if nothing was stored since reset.
- R9: A sample is stored only at a clock edge where `tick_i` and `locked_i` are 1, the block is not in holdover and not entering it. Other ticks leave the average unchanged.
- R10: The history keeps the 128 newest samples. Older ones are overwritten and can no longer affect the average.
- R11: `hold_freq_o` changes only in the cycle in which `avg_ready_o` rises. `avg_ready_o` stays 1 until holdover ends and is never 1 outside holdover.
- R12: The window and delay codes are latched at holdover entry. Changing them during holdover has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| samp_i | input | DATA_W | Frequency-word sample from the loop |
| tick_i | input | 1 | Sample strobe, one cycle wide |
| locked_i | input | 1 | Loop is locked to the selected reference |
| sel_valid_i | input | 1 | Selected reference is valid |
| alt_valid_i | input | 1 | At least one other reference is valid |
| win_sel_i | input | 2 | Averaging window code |
| dly_sel_i | input | 3 | Exclusion delay code |
| hold_freq_o | output | DATA_W | Held (averaged) frequency word |
| hold_active_o | output | 1 | Holdover in progress |
| avg_ready_o | output | 1 | Held word of the current holdover is valid |

## Verification
On every cycle, the assertions check the entry and exit timing of holdover, the cleared outputs after reset, and that the ready flag never appears outside holdover. They also check that the held word moves only together with a rising ready flag. The bench scenarios are the only place that shows the averaged value itself. That covers the window and delay decoding, the clipping when the history is short, the fallback to the newest sample, and wrap-around of the history. The scenarios also show that samples offered while unlocked or in holdover are ignored, and that select changes made during holdover do not reach the result.

// File: rtl/hold_avg_pkg.sv
package hold_avg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_DIV  = 2'd2,
        ST_DONE = 2'd3
    } avg_state_e;

endpackage

// File: rtl/hold_avg_hist.sv
module hold_avg_hist #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [AW-1:0]     rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [AW-1:0]     wr_ptr_o,
    output logic [CW-1:0]     count_o,
    output logic [DATA_W-1:0] last_o
);

    typedef struct packed {
        logic [AW-1:0]     ptr;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] last;
    } hist_t;

    hist_t q, d;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (wr_en_i) begin
            d.ptr  = q.ptr + AW'(1);
            d.last = wr_data_i;
            if (q.cnt != CW'(DEPTH)) begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            mem[q.ptr] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[rd_idx_i];
    assign wr_ptr_o  = q.ptr;
    assign count_o   = q.cnt;
    assign last_o    = q.last;

endmodule

// File: rtl/hold_avg_span.sv
module hold_avg_span #(
    parameter int DEPTH = 128,
    parameter int WIN0  = 4,
    parameter int WIN1  = 10,
    parameter int WIN2  = 30,
    parameter int WIN3  = 60,
    parameter int DLY0  = 1,
    parameter int DLY1  = 2,
    parameter int DLY2  = 4,
    parameter int DLY3  = 10,
    parameter int DLY4  = 30,
    parameter int DLY5  = 60,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic [1:0]    win_sel_i,
    input  logic [2:0]    dly_sel_i,
    input  logic [CW-1:0] count_i,
    input  logic [AW-1:0] wr_ptr_i,
    output logic [CW-1:0] n_o,
    output logic [AW-1:0] start_o
);

    logic [CW-1:0] win_t;
    logic [CW-1:0] dly_t;
    logic [CW-1:0] avail;

    always_comb begin
        unique case (win_sel_i)
            2'd0:    win_t = CW'(WIN0);
            2'd1:    win_t = CW'(WIN1);
            2'd2:    win_t = CW'(WIN2);
            default: win_t = CW'(WIN3);
        endcase
        case (dly_sel_i)
            3'd0:    dly_t = CW'(DLY0);
            3'd1:    dly_t = CW'(DLY1);
            3'd2:    dly_t = CW'(DLY2);
            3'd3:    dly_t = CW'(DLY3);
            3'd4:    dly_t = CW'(DLY4);
            default: dly_t = CW'(DLY5);
        endcase
        avail   = (count_i > dly_t) ? (count_i - dly_t) : '0;
        n_o     = (avail < win_t) ? avail : win_t;
        start_o = wr_ptr_i - AW'(1) - AW'(dly_t);
    end

endmodule

// File: rtl/hold_avg_div.sv
module hold_avg_div #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 8,
    parameter int Q_W   = 16,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [Q_W-1:0]   quot_o
);

    typedef struct packed {
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] rem;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } div_t;

    div_t q, d;
    logic [DEN_W:0] trial;
    logic           fits;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.quo[NUM_W-1]};
        fits   = (trial >= {1'b0, den_i});
        if (start_i) begin
            d.quo  = num_i;
            d.rem  = '0;
            d.cnt  = CNT_W'(NUM_W);
            d.busy = 1'b1;
        end else if (q.busy) begin
            d.rem = fits ? DEN_W'(trial - {1'b0, den_i}) : DEN_W'(trial);
            d.quo = {q.quo[NUM_W-2:0], fits};
            d.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign quot_o = q.quo[Q_W-1:0];

endmodule

// File: rtl/hold_avg_top.sv
module hold_avg_top #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 128,
    parameter int WIN0   = 4,
    parameter int WIN1   = 10,
    parameter int WIN2   = 30,
    parameter int WIN3   = 60,
    parameter int DLY0   = 1,
    parameter int DLY1   = 2,
    parameter int DLY2   = 4,
    parameter int DLY3   = 10,
    parameter int DLY4   = 30,
    parameter int DLY5   = 60
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] samp_i,
    input  logic              tick_i,
    input  logic              locked_i,
    input  logic              sel_valid_i,
    input  logic              alt_valid_i,
    input  logic [1:0]        win_sel_i,
    input  logic [2:0]        dly_sel_i,
    output logic [DATA_W-1:0] hold_freq_o,
    output logic              hold_active_o,
    output logic              avg_ready_o
);

    import hold_avg_pkg::*;

    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = AW + 1;
    localparam int SUM_W = DATA_W + CW;

    typedef struct packed {
        avg_state_e        st;
        logic [AW-1:0]     rd_idx;
        logic [CW-1:0]     left;
        logic [CW-1:0]     den;
        logic [SUM_W-1:0]  sum;
        logic [DATA_W-1:0] held;
        logic              hold;
        logic              ready;
        logic              go;
    } top_t;

    top_t q, d;

    logic              want_hold;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;
    logic [AW-1:0]     wr_ptr;
    logic [CW-1:0]     count;
    logic [DATA_W-1:0] last;
    logic [CW-1:0]     span_n;
    logic [AW-1:0]     span_start;
    logic              div_done;
    logic [DATA_W-1:0] div_quot;

    assign want_hold = !sel_valid_i && !alt_valid_i;
    assign wr_en     = tick_i && locked_i && !want_hold && !q.hold;

    hold_avg_hist #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) hist_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wr_en_i  (wr_en),
        .wr_data_i(samp_i),
        .rd_idx_i (q.rd_idx),
        .rd_data_o(rd_data),
        .wr_ptr_o (wr_ptr),
        .count_o  (count),
        .last_o   (last)
    );

    hold_avg_span #(
        .DEPTH(DEPTH),
        .WIN0(WIN0), .WIN1(WIN1), .WIN2(WIN2), .WIN3(WIN3),
        .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2),
        .DLY3(DLY3), .DLY4(DLY4), .DLY5(DLY5)
    ) span_i (
        .win_sel_i(win_sel_i),
        .dly_sel_i(dly_sel_i),
        .count_i  (count),
        .wr_ptr_i (wr_ptr),
        .n_o      (span_n),
        .start_o  (span_start)
    );

    hold_avg_div #(
        .NUM_W(SUM_W),
        .DEN_W(CW),
        .Q_W  (DATA_W)
    ) div_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .start_i(q.go),
        .num_i  (q.sum),
        .den_i  (q.den),
        .done_o (div_done),
        .quot_o (div_quot)
    );

    always_comb begin
        d    = q;
        d.go = 1'b0;
        if (!q.hold) begin
            if (want_hold) begin
                d.hold  = 1'b1;
                d.ready = 1'b0;
                if (span_n == '0) begin
                    d.held  = last;
                    d.ready = 1'b1;
                    d.st    = ST_DONE;
                end else begin
                    d.st     = ST_ACC;
                    d.rd_idx = span_start;
                    d.left   = span_n;
                    d.den    = span_n;
                    d.sum    = '0;
                end
            end
        end else if (!want_hold) begin
            d.hold  = 1'b0;
            d.ready = 1'b0;
            d.st    = ST_IDLE;
        end else begin
            unique case (q.st)
                ST_ACC: begin
                    d.sum    = q.sum + SUM_W'(rd_data);
                    d.rd_idx = q.rd_idx - AW'(1);
                    d.left   = q.left - CW'(1);
                    if (q.left == CW'(1)) begin
                        d.st = ST_DIV;
                        d.go = 1'b1;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        d.held  = div_quot;
                        d.ready = 1'b1;
                        d.st    = ST_DONE;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign hold_freq_o   = q.held;
    assign hold_active_o = q.hold;
    assign avg_ready_o   = q.ready;

endmodule

// File: rtl/hold_avg_chk.sv
module hold_avg_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              sel_valid_i,
    input logic              alt_valid_i,
    input logic [DATA_W-1:0] hold_freq_o,
    input logic              hold_active_o,
    input logic              avg_ready_o
);

    logic seen_q = 1'b0;
    always_ff @(posedge clk_i) seen_q <= 1'b1;

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        (seen_q && $past(rst_i)) |-> (!hold_active_o && !avg_ready_o && hold_freq_o == '0));

    assert_enter_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!hold_active_o && !sel_valid_i && !alt_valid_i) |=> hold_active_o);

    assert_stay_out_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!hold_active_o && (sel_valid_i || alt_valid_i)) |=> !hold_active_o);

    assert_leave_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (hold_active_o && (sel_valid_i || alt_valid_i)) |=> (!hold_active_o && !avg_ready_o));

    assert_held_stable_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && !$past(rst_i) && !$stable(hold_freq_o)) |-> $rose(avg_ready_o));

    assert_ready_in_hold_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        avg_ready_o |-> hold_active_o);

endmodule

bind hold_avg_top hold_avg_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .sel_valid_i  (sel_valid_i),
    .alt_valid_i  (alt_valid_i),
    .hold_freq_o  (hold_freq_o),
    .hold_active_o(hold_active_o),
    .avg_ready_o  (avg_ready_o)
);

// File: tb/hold_avg_top_tb_top.sv
module hold_avg_top_tb_top;

    localparam int DW    = 16;
    localparam int DEPTH = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] samp = '0;
    logic          tick = 1'b0;
    logic          locked = 1'b1;
    logic          sel_valid = 1'b1;
    logic          alt_valid = 1'b0;
    logic [1:0]    win_sel = '0;
    logic [2:0]    dly_sel = '0;
    logic [DW-1:0] hold_freq;
    logic          hold_active;
    logic          avg_ready;

    int n_cmp = 0;
    int n_bad = 0;
    int hist[$];
    int exp_q[$];
    string tag_q[$];
    int n_ready_seen = 0;
    int WT[4] = '{4, 10, 30, 60};
    int DT[8] = '{1, 2, 4, 10, 30, 60, 60, 60};

    always #4 clk = ~clk;

    hold_avg_top dut_i (
        .clk_i(clk), .rst_i(rst), .samp_i(samp), .tick_i(tick),
        .locked_i(locked), .sel_valid_i(sel_valid), .alt_valid_i(alt_valid),
        .win_sel_i(win_sel), .dly_sel_i(dly_sel), .hold_freq_o(hold_freq),
        .hold_active_o(hold_active), .avg_ready_o(avg_ready)
    );

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_avg(int w, int d);
        int c = (hist.size() > DEPTH) ? DEPTH : hist.size();
        int avail = (c > d) ? c - d : 0;
        int n = (avail < w) ? avail : w;
        longint s = 0;
        if (n == 0) return (hist.size() == 0) ? 0 : hist[hist.size()-1];
        for (int k = 0; k < n; k++) s += hist[hist.size() - 1 - d - k];
        return int'(s / n);
    endfunction

    // monitor: scoreboard pop on each rising ready flag, held word watched otherwise
    logic          prev_ready = 1'b0;
    logic [DW-1:0] prev_freq = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (avg_ready && !prev_ready) begin
                n_ready_seen++;
                if (exp_q.size() == 0) begin
                    check("R11 unexpected ready", 1, 0);
                end else begin
                    check(tag_q.pop_front(), int'(hold_freq), exp_q.pop_front());
                end
            end else if (hold_freq != prev_freq) begin
                check("R11 held word moved without ready", int'(hold_freq), int'(prev_freq));
            end
        end
        prev_ready = avg_ready;
        prev_freq  = hold_freq;
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sel_valid = 1'b1; alt_valid = 1'b0; tick = 1'b0; locked = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        hist.delete();
        check("R1 hold_active", int'(hold_active), 0);
        check("R1 avg_ready", int'(avg_ready), 0);
        check("R1 hold_freq", int'(hold_freq), 0);
    endtask

    task automatic put(int v, bit lk);
        @(negedge clk);
        samp = DW'(v); tick = 1'b1; locked = lk;
        @(negedge clk);
        tick = 1'b0; locked = 1'b1;
        if (lk && !hold_active) hist.push_back(v & 16'hFFFF);
    endtask

    // driver: push expected value, then fail the references
    task automatic enter(int w, int d, string tag, bit twist);
        int seen0 = n_ready_seen;
        exp_q.push_back(model_avg(WT[w], DT[d]));
        tag_q.push_back(tag);
        @(negedge clk);
        win_sel = 2'(w); dly_sel = 3'(d); sel_valid = 1'b0; alt_valid = 1'b0;
        @(negedge clk);
        check("R2 entry one cycle later", int'(hold_active), 1);
        if (twist) begin  // R12: codes changed during accumulation
            win_sel = 2'(3 - w); dly_sel = 3'(7 - d);
        end
        for (int i = 0; i < 3000 && n_ready_seen == seen0; i++) @(negedge clk);
        check({tag, " ready reached"}, n_ready_seen - seen0, 1);
    endtask

    task automatic leave(bit use_alt);
        @(negedge clk);
        if (use_alt) alt_valid = 1'b1; else sel_valid = 1'b1;
        @(negedge clk);
        check("R3 hold_active cleared", int'(hold_active), 0);
        check("R3 avg_ready cleared", int'(avg_ready), 0);
        alt_valid = 1'b0; sel_valid = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : driver
        do_reset();
        // R2: alternate reference keeps holdover off
        @(negedge clk); sel_valid = 1'b0; alt_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 alt valid blocks entry", int'(hold_active), 0);
        sel_valid = 1'b1; alt_valid = 1'b0;

        for (int i = 0; i < 70; i++) put(1000 + 3 * i, 1'b1);
        enter(1, 2, "R4 win10 dly4", 1'b0);
        // R9: ticks during holdover are not stored
        for (int i = 0; i < 5; i++) put(60000, 1'b1);
        leave(1'b0);
        enter(1, 2, "R12 selects changed mid-holdover", 1'b1);
        leave(1'b1);
        for (int i = 0; i < 5; i++) put(50000, 1'b0);   // R9 unlocked ticks dropped
        for (int i = 0; i < 12; i++) put(2000 + 7 * i, 1'b1);
        enter(0, 0, "R5 R9 win4 dly1", 1'b0);
        leave(1'b0);
        enter(2, 1, "R5 win30 dly2", 1'b0);
        leave(1'b0);

        do_reset();
        for (int i = 0; i < 6; i++) put(300 + 11 * i, 1'b1);
        enter(3, 0, "R7 short history", 1'b0);
        leave(1'b0);

        do_reset();
        enter(0, 0, "R8 empty history", 1'b0);
        leave(1'b0);
        for (int i = 0; i < 3; i++) put(777 + i, 1'b1);
        enter(0, 3, "R8 nothing older than delay", 1'b0);
        leave(1'b0);

        do_reset();
        for (int i = 0; i < 200; i++) put((i * 37 + 5) % 4096 + i * 11, 1'b1);
        enter(3, 7, "R6 R10 code7 after wrap", 1'b0);
        leave(1'b0);
        enter(3, 5, "R6 R10 code5 after wrap", 1'b0);
        leave(1'b0);
        enter(2, 4, "R6 dly30", 1'b0);
        leave(1'b0);
        enter(0, 6, "R6 code6", 1'b0);
        leave(1'b0);

        repeat (4) @(negedge clk);
        check("R11 queue drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule